// File: doc/BRIEF.md
# Battery Discharge Overcurrent Hiccup Controller

This block guards the battery discharge switch. It watches a digitised overcurrent comparator and turns the switch off when the comparator stays set for a whole deglitch window. The switch stays off for a fixed off period and is then tried again. Every retry that runs into overcurrent again counts as a failure. When the number of consecutive failures reaches a limit set in a register field, the switch stays off until a release condition is met.

The release condition depends on how the sequence began. If the battery was feeding the system in supplement mode while the input supply was present, the input has to go away and come back. In every other case a valid input supply, or a device reset, is enough. The first turn-off of each sequence sets a sticky fault flag and sends one interrupt pulse.

A separate path forces the charger to the precharge current whenever the battery short comparator trips during charging. All thresholds are sensed outside the block. Time windows are counted in clock cycles.

Top module: `bat_ocp_hiccup`

## Requirements
- R1: While the switch is enabled, `ocp_cmp` high for DEGLITCH_CYC consecutive clock cycles drops `fet_en` at the clock edge that samples the last of those cycles. Any shorter burst leaves `fet_en` high.
- R2: After a turn-off that does not reach the failure limit, `fet_en` stays low for exactly OFF_CYC cycles and then goes high again for a retry.
- R3: A retry in which `ocp_cmp` stays high for DEGLITCH_CYC consecutive cycles is a failed retry. When the number of consecutive failed retries reaches the limit, `fet_en` stays low with no time bound.
- R4: The failure limit is the 3-bit field `retry_limit`. Values 0, 1 and 2 act as 3, and values 3 to 7 are used as given.
- R5: A retry in which `ocp_cmp` stays low for DEGLITCH_CYC consecutive cycles ends the sequence and restores normal operation. The next overcurrent then starts a new sequence with a zero failure count.
- R6: The latched-off state is left on the clock edge after `vin_valid` is high, once at least OFF_CYC cycles have passed in that state. This holds when the sequence did not start with `suppl_active` and `vin_valid` both high.
- R7: When the first turn-off of the sequence saw `suppl_active` and `vin_valid` both high, a steady high `vin_valid` does not release the latch. Only a low and then high `vin_valid` does.
- R8: Asserting `rst_n` clears the latch, the failure count and the flag at once, and leaves `fet_en` high.
- R9: The first turn-off of a sequence sets `fault_flag` and drives `irq` high for exactly one cycle. Failed retries do not pulse `irq`. `flag_clr` clears the flag, but a setting event in the same cycle wins.
- R10: `force_prechg` equals (`short_cmp` AND `charging`) as sampled at the previous clock edge.
- R11: Out of reset, `fet_en` is 1 and `force_prechg`, `fault_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| ocp_cmp | input | 1 | Discharge overcurrent comparator, high = overcurrent |
| short_cmp | input | 1 | Battery below short threshold, high = collapsed |
| vin_valid | input | 1 | Input supply present and valid |
| suppl_active | input | 1 | Battery supplementing the system load |
| charging | input | 1 | Charge cycle in progress |
| retry_limit | input | LIM_W | Consecutive failed retries before latch-off, clamped to at least 3 |
| flag_clr | input | 1 | Clears the sticky fault flag |
| fet_en | output | 1 | Battery discharge switch enable |
| force_prechg | output | 1 | Forces the charge current to the precharge level |
| fault_flag | output | 1 | Sticky overcurrent fault flag |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Random overcurrent bursts one cycle shorter than the window or less must never open the switch. A filter that is off by one, or that does not restart on a gap, would drop `fet_en` early. Full runs to latch-off are made with limits 0, 3, 5 and 7. A clamp that is missing or one count off would latch one hiccup too early or too late. A retry that succeeds between failures must restart the count, or the switch would latch on the wrong hiccup. The supplement-mode case holds `vin_valid` high for a long time before toggling it. A release rule that ignores the recorded mode would reconnect the switch without the toggle. The precharge path is checked cycle by cycle against random `short_cmp` and `charging` patterns.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_ON    = 2'd0,
    ST_OFF   = 2'd1,
    ST_RETRY = 2'd2,
    ST_LATCH = 2'd3
  } hic_state_t;
endpackage

// File: rtl/ocp_rst_sync.sv
module ocp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ocp_run_timer.sv
// Counts consecutive cycles in which sense equals LEVEL while en is high.
// done is high in the cycle that completes RUN_CYC such cycles.
module ocp_run_timer #(
  parameter int RUN_CYC = 16,
  parameter bit LEVEL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sense,
  output logic done
);
  localparam int CW = $clog2(RUN_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          match;

  assign match = (sense == LEVEL);
  assign done  = en && match && (cnt_q == CW'(RUN_CYC - 1));

  always_comb begin
    if (!en || !match || done) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocp_short_force.sv
module ocp_short_force (
  input  logic clk,
  input  logic rst_n,
  input  logic short_cmp,
  input  logic charging,
  output logic force_prechg
);
  logic force_d, force_q;

  always_comb force_d = short_cmp & charging;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= force_d;
  end

  assign force_prechg = force_q;
endmodule

// File: rtl/ocp_hiccup_fsm.sv
module ocp_hiccup_fsm
  import ocp_pkg::*;
#(
  parameter int OFF_CYC = 1000,
  parameter int LIM_W   = 3,
  parameter int LIM_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip,
  input  logic             quiet,
  input  logic             vin_valid,
  input  logic             suppl_active,
  input  logic             flag_clr,
  input  logic [LIM_W-1:0] retry_limit,
  output logic             mon_en,
  output logic             retry_win,
  output logic             fet_en,
  output logic             fault_flag,
  output logic             irq
);
  localparam int OW = $clog2(OFF_CYC + 1);

  hic_state_t       st_q, st_d;
  logic [OW-1:0]    off_q, off_d;
  logic [LIM_W-1:0] fail_q, fail_d;
  logic [LIM_W-1:0] lim;
  logic             mode_q, mode_d;     // sequence began in supplement mode with input present
  logic             seen_q, seen_d;     // input seen low while latched
  logic             flag_q, flag_d;
  logic             irq_q, irq_d;
  logic             off_done, first_trip, release_ok;

  assign lim      = (retry_limit < LIM_W'(LIM_MIN)) ? LIM_W'(LIM_MIN) : retry_limit;
  assign off_done = (off_q == OW'(OFF_CYC - 1));
  assign release_ok = off_done && vin_valid && (!mode_q || seen_q);

  always_comb begin
    st_d       = st_q;
    off_d      = off_q;
    fail_d     = fail_q;
    mode_d     = mode_q;
    seen_d     = seen_q;
    first_trip = 1'b0;
    unique case (st_q)
      ST_ON: begin
        if (trip) begin
          st_d       = ST_OFF;
          off_d      = '0;
          fail_d     = '0;
          mode_d     = suppl_active & vin_valid;
          first_trip = 1'b1;
        end
      end
      ST_OFF: begin
        if (off_done) st_d  = ST_RETRY;
        else          off_d = off_q + 1'b1;
      end
      ST_RETRY: begin
        if (trip) begin
          off_d = '0;
          if ({1'b0, fail_q} + 1'b1 >= {1'b0, lim}) begin
            st_d   = ST_LATCH;
            seen_d = 1'b0;
          end else begin
            st_d   = ST_OFF;
            fail_d = fail_q + 1'b1;
          end
        end else if (quiet) begin
          st_d   = ST_ON;
          fail_d = '0;
        end
      end
      ST_LATCH: begin
        if (!off_done) off_d = off_q + 1'b1;
        if (!vin_valid) seen_d = 1'b1;
        if (release_ok) begin
          st_d   = ST_ON;
          fail_d = '0;
        end
      end
      default: st_d = ST_ON;
    endcase
  end

  always_comb begin
    irq_d = first_trip;
    if (first_trip)    flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ON;
      off_q  <= '0;
      fail_q <= '0;
      mode_q <= 1'b0;
      seen_q <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      off_q  <= off_d;
      fail_q <= fail_d;
      mode_q <= mode_d;
      seen_q <= seen_d;
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign mon_en     = (st_q == ST_ON) || (st_q == ST_RETRY);
  assign retry_win  = (st_q == ST_RETRY);
  assign fet_en     = mon_en;
  assign fault_flag = flag_q;
  assign irq        = irq_q;
endmodule

// File: rtl/bat_ocp_hiccup.sv
module bat_ocp_hiccup #(
  parameter int DEGLITCH_CYC = 16,
  parameter int OFF_CYC      = 1000,
  parameter int LIM_W        = 3,
  parameter int LIM_MIN      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ocp_cmp,
  input  logic             short_cmp,
  input  logic             vin_valid,
  input  logic             suppl_active,
  input  logic             charging,
  input  logic [LIM_W-1:0] retry_limit,
  input  logic             flag_clr,
  output logic             fet_en,
  output logic             force_prechg,
  output logic             fault_flag,
  output logic             irq
);
  logic rst_sync_n;
  logic mon_en, retry_win, trip, quiet;

  ocp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ocp_run_timer #(.RUN_CYC(DEGLITCH_CYC), .LEVEL(1'b1)) u_hi_run (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (mon_en),
    .sense (ocp_cmp),
    .done  (trip)
  );

  ocp_run_timer #(.RUN_CYC(DEGLITCH_CYC), .LEVEL(1'b0)) u_lo_run (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (retry_win),
    .sense (ocp_cmp),
    .done  (quiet)
  );

  ocp_hiccup_fsm #(.OFF_CYC(OFF_CYC), .LIM_W(LIM_W), .LIM_MIN(LIM_MIN)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .trip         (trip),
    .quiet        (quiet),
    .vin_valid    (vin_valid),
    .suppl_active (suppl_active),
    .flag_clr     (flag_clr),
    .retry_limit  (retry_limit),
    .mon_en       (mon_en),
    .retry_win    (retry_win),
    .fet_en       (fet_en),
    .fault_flag   (fault_flag),
    .irq          (irq)
  );

  ocp_short_force u_force (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .short_cmp    (short_cmp),
    .charging     (charging),
    .force_prechg (force_prechg)
  );
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk #(
  parameter int OFF_CYC = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic ocp_cmp,
  input logic short_cmp,
  input logic charging,
  input logic flag_clr,
  input logic fet_en,
  input logic force_prechg,
  input logic fault_flag,
  input logic irq
);
  localparam int RW = $clog2(OFF_CYC + 2);
  logic [RW-1:0] off_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        off_run <= '0;
    else if (fet_en)                   off_run <= '0;
    else if (off_run != RW'(OFF_CYC))  off_run <= off_run + 1'b1;
  end

  p_trip_needs_ocp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fet_en) |-> $past(ocp_cmp));

  p_off_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fet_en) |-> (off_run >= RW'(OFF_CYC)));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fault_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !flag_clr) |=> fault_flag);

  p_force_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (short_cmp && charging) |=> force_prechg);

  p_force_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_cmp && charging) |=> !force_prechg);
endmodule

bind bat_ocp_hiccup ocp_hiccup_chk #(.OFF_CYC(OFF_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ocp_cmp      (ocp_cmp),
  .short_cmp    (short_cmp),
  .charging     (charging),
  .flag_clr     (flag_clr),
  .fet_en       (fet_en),
  .force_prechg (force_prechg),
  .fault_flag   (fault_flag),
  .irq          (irq)
);

// File: tb/bat_ocp_hiccup_test.sv
`timescale 1ns/1ps
module bat_ocp_hiccup_test;
  localparam int DEG = 6;
  localparam int OFF = 24;
  localparam real HALF = 2.0;

  logic       clk = 1'b0;
  logic       rst_n, ocp_cmp, short_cmp, vin_valid, suppl_active, charging, flag_clr;
  logic [2:0] retry_limit;
  logic       fet_en, force_prechg, fault_flag, irq;

  int checks = 0;
  int errors = 0;
  int irq_seen = 0;

  always #(HALF) clk = ~clk;

  bat_ocp_hiccup #(.DEGLITCH_CYC(DEG), .OFF_CYC(OFF), .LIM_W(3), .LIM_MIN(3)) uut (
    .clk(clk), .rst_n(rst_n), .ocp_cmp(ocp_cmp), .short_cmp(short_cmp),
    .vin_valid(vin_valid), .suppl_active(suppl_active), .charging(charging),
    .retry_limit(retry_limit), .flag_clr(flag_clr), .fet_en(fet_en),
    .force_prechg(force_prechg), .fault_flag(fault_flag), .irq(irq)
  );

  always @(posedge clk) if (irq === 1'b1) irq_seen++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_force(input logic s, input logic c);
    return s & c;
  endfunction

  function automatic int eff_limit(input int field);
    return (field < 3) ? 3 : field;
  endfunction

  // One overcurrent event lasting a full window, then the off period.
  task automatic hiccup(input bit expect_latch, input bit expect_irq);
    int base = irq_seen;
    ocp_cmp = 1'b1;
    step(DEG - 1);
    check("R1 on before window ends", fet_en, 1);
    step(1);
    check("R1 off at window end", fet_en, 0);
    check("R9 irq on first trip only", irq, expect_irq ? 1 : 0);
    ocp_cmp = 1'b0;
    if (expect_latch) begin
      step(OFF + 3);
      check("R3 latched off", fet_en, 0);
    end else begin
      step(OFF - 1);
      check("R2 still off", fet_en, 0);
      step(1);
      check("R2 retry on", fet_en, 1);
    end
    check("R9 irq count", irq_seen - base, expect_irq ? 1 : 0);
  endtask

  task automatic run_to_latch(input int lim);
    hiccup(1'b0, 1'b1);
    for (int i = 1; i < lim; i++) hiccup(1'b0, 1'b0);
    hiccup(1'b1, 1'b0);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; ocp_cmp = 1'b0; short_cmp = 1'b0; vin_valid = 1'b0;
    suppl_active = 1'b0; charging = 1'b0; flag_clr = 1'b0; retry_limit = 3'd3;
    step(3);
    rst_n = 1'b1;
    step(4);
    check("R11 fet_en", fet_en, 1);
    check("R11 force", force_prechg, 0);
    check("R11 flag", fault_flag, 0);
    check("R11 irq", irq, 0);

    // R1: short random bursts never open the switch
    for (int i = 0; i < 10; i++) begin
      int len = 1 + int'($urandom % (DEG - 1));
      ocp_cmp = 1'b1;
      step(len);
      ocp_cmp = 1'b0;
      step(1);
      check("R1 burst ignored", fet_en, 1);
    end

    // R4: field 0 acts as 3; R6: release by valid input
    retry_limit = 3'd0;
    run_to_latch(eff_limit(0));
    check("R9 flag set", fault_flag, 1);
    vin_valid = 1'b1;
    step(1);
    check("R6 release by vin", fet_en, 1);
    vin_valid = 1'b0;
    step(2);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check("R9 flag cleared", fault_flag, 0);

    // R5: successful retry ends the sequence
    retry_limit = 3'd3;
    hiccup(1'b0, 1'b1);
    hiccup(1'b0, 1'b0);
    hiccup(1'b0, 1'b0);
    step(DEG);
    check("R5 back to normal", fet_en, 1);
    run_to_latch(3);
    vin_valid = 1'b1;
    step(1);
    check("R6 release", fet_en, 1);
    vin_valid = 1'b0;
    step(2);

    // R4: limits 5 and 7 used directly
    retry_limit = 3'd5;
    run_to_latch(eff_limit(5));
    vin_valid = 1'b1; step(1);
    check("R4 release after limit 5", fet_en, 1);
    vin_valid = 1'b0; step(2);
    retry_limit = 3'd7;
    run_to_latch(eff_limit(7));
    vin_valid = 1'b1; step(1);
    check("R4 release after limit 7", fet_en, 1);
    step(2);

    // R7: supplement mode with input present needs a toggle
    suppl_active = 1'b1;
    retry_limit = 3'd3;
    run_to_latch(3);
    suppl_active = 1'b0;
    step(20);
    check("R7 steady vin keeps latch", fet_en, 0);
    vin_valid = 1'b0;
    step(2);
    check("R7 vin low keeps latch", fet_en, 0);
    vin_valid = 1'b1;
    step(1);
    check("R7 release after toggle", fet_en, 1);
    vin_valid = 1'b0;
    step(2);

    // R8: reset clears a latch
    run_to_latch(3);
    rst_n = 1'b0;
    #1;
    check("R8 fet on in reset", fet_en, 1);
    check("R8 flag cleared", fault_flag, 0);
    step(1);
    rst_n = 1'b1;
    step(4);
    check("R8 fet on after reset", fet_en, 1);

    // R10: random short/charging patterns
    begin
      logic ps = 1'b0, pc = 1'b0;
      for (int i = 0; i < 300; i++) begin
        if (i > 0) check("R10 force_prechg", force_prechg, exp_force(ps, pc));
        ps = 1'($urandom % 2);
        pc = 1'($urandom % 2);
        short_cmp = ps;
        charging = pc;
        step(1);
      end
      short_cmp = 1'b0;
      charging = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule